// File: doc/BRIEF.md
# I2C Slave with Stretch Control

This block is an I2C bus slave with a fixed 7-bit address. It has a small register interface for a local processor. SCL and SDA are sampled in the system clock domain. The block finds Start and Stop conditions and compares the address byte with its own address.

For a write transfer, the block assembles each data byte in a shift register. It then decides whether to accept the byte into a one-byte holding buffer. The decision depends on two flags: buffer-full and overrun. The block acknowledges accepted bytes and refuses the others.

For a read transfer, the block holds SCL low after the address and after each byte the master acknowledges. While SCL is held, the processor loads the buffer, which also loads the shift register. The processor then sets a clock-release bit, and the byte is shifted out MSB first. An event flag marks the end of every byte the block takes part in, and stays set until the processor clears it. Both bus outputs are open-drain low enables.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset, buffer-full, overrun, event flag and release bit read 0, and neither SCL nor SDA is pulled low.
- R2: An address byte is taken MSB first as seven address bits then a direction bit (0 = master writes, 1 = master reads). On a match, the slave pulls SDA low through the ninth clock and sets the event flag at the ninth falling SCL edge.
- R3: On an address mismatch, the slave does not pull SDA low and does not set the event flag for that byte or any later byte until a new Start.
- R4: A received data byte that completes while buffer-full=0 and overrun=0 is moved to the buffer. Buffer-full is set, the byte is acknowledged, and the event flag is set.
- R5: A received data byte that completes while buffer-full=1 is refused (SDA stays high on the ninth clock). The buffer keeps its old value, overrun is set, and the event flag is still set.
- R6: While overrun=1, every received data byte is refused and not buffered, even with buffer-full=0. Once the processor clears overrun, bytes are accepted again.
- R7: A buffer read strobe clears buffer-full. The event-clear strobe clears the event flag, and the overrun-clear strobe clears overrun.
- R8: After a matching address with direction 1, the slave holds SCL low after the ninth clock. It also sets the event flag and clears the release bit.
- R9: A release request has no effect until the buffer has been written during the current hold. After a write and a release, SCL is freed and the written byte is sent MSB first.
- R10: The master's acknowledge is sampled on the ninth rising SCL edge. Low (ACK) makes the slave hold SCL again and clear the release bit. High (NACK) frees the bus, clears buffer-full and the release bit, and ignores the bus until a new Start.
- R11: A Stop condition returns the slave to idle from any state, and the bus is then ignored until a new Start.
- R12: The SDA pull-down changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr_i | input | 7 | Slave address to match |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_low_o | output | 1 | Pull SDA low when 1 |
| buf_wr_i | input | 1 | Buffer write strobe (also loads the shifter during a hold) |
| buf_wdata_i | input | 8 | Buffer write data |
| buf_rd_i | input | 1 | Buffer read strobe, clears buffer-full |
| buf_rdata_o | output | 8 | Buffer contents |
| rel_set_i | input | 1 | Request to set the clock-release bit |
| irq_clr_i | input | 1 | Clears the event flag |
| ovf_clr_i | input | 1 | Clears the overrun flag |
| buf_full_o | output | 1 | Buffer-full flag |
| ovf_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Per-byte event flag |
| rel_o | output | 1 | Clock-release bit |

## Verification
A bus edge reaches the slave's outputs three clock edges later: two synchronizer flops, then the state register. The bench keeps every SCL phase at least eight clocks long and samples SDA, acknowledges and flags in the middle of a phase, well past that delay. Processor strobes last one clock and take effect at the next edge, so the flags are read at the falling clock edge that follows. The hold on SCL is checked a few clocks after the ninth falling edge, and again after a long wait with no buffer write, to show that the release request was ignored.

// File: rtl/i2c_ss_pkg.sv
package i2c_ss_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX_WAIT,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } ss_state_e;

  // single-cycle events from the bus engine to the register bank
  typedef struct packed {
    logic rx_load;   // move shifted byte into buffer, set buffer-full
    logic ovf_set;   // byte arrived while buffer still full
    logic irq_set;   // ninth falling edge of a handled byte
    logic rel_clr;   // entering a clock hold
    logic st_reset;  // master ended a read with NACK
  } ss_evt_t;

endpackage

// File: rtl/i2c_ss_sync.sv
module i2c_ss_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_sync_n,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0]             rst_pipe_q;
  logic [SYNC_STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic                   scl_d_q, sda_d_q;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // bus lines idle high, so synchronizers reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
      scl_d_q    <= scl_pipe_q[SYNC_STAGES-1];
      sda_d_q    <= sda_pipe_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe_q[SYNC_STAGES-1];
  assign sda_s     = sda_pipe_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d_q;
  assign scl_fall  = ~scl_s & scl_d_q;
  assign start_det = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_det  = scl_s & scl_d_q & ~sda_d_q & sda_s;

endmodule

// File: rtl/i2c_ss_ctrl.sv
module i2c_ss_ctrl
  import i2c_ss_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] own_addr_i,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          bf_i,
  input  logic          ovf_i,
  input  logic          rel_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  output logic          sda_low_o,
  output logic          scl_low_o,
  output ss_evt_t       evt_o,
  output logic [DW-1:0] rx_data_o
);

  localparam int AW = DW - 1;
  localparam int CW = $clog2(DW + 1);

  ss_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] shift_q, shift_d;
  logic          sda_low_q, sda_low_d;
  logic          rw_q, rw_d;
  logic          nack_q, nack_d;
  logic          accept;

  assign accept = ~bf_i & ~ovf_i;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    shift_d   = shift_q;
    sda_low_d = sda_low_q;
    rw_d      = rw_q;
    nack_d    = nack_q;
    evt_o     = '0;
    if (stop_det) begin
      state_d   = ST_IDLE;
      sda_low_d = 1'b0;
      cnt_d     = '0;
    end else if (start_det) begin
      state_d   = ST_ADDR;
      sda_low_d = 1'b0;
      cnt_d     = '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && cnt_q != CW'(DW)) begin
            shift_d = {shift_q[DW-2:0], sda_s};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CW'(DW)) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (shift_q[DW-1 -: AW] == own_addr_i) begin
                rw_d      = shift_q[0];
                sda_low_d = 1'b1;
                state_d   = ST_ADDR_ACK;
              end else begin
                state_d = ST_IGNORE;
              end
            end else begin
              evt_o.rx_load = accept;
              evt_o.ovf_set = bf_i;
              sda_low_d     = accept;
              state_d       = ST_RX_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_RX_ACK: begin
          if (scl_fall) begin
            sda_low_d     = 1'b0;
            evt_o.irq_set = 1'b1;
            if (state_q == ST_ADDR_ACK && rw_q) begin
              state_d       = ST_TX_WAIT;
              evt_o.rel_clr = 1'b1;
            end else begin
              state_d = ST_RX;
            end
          end
        end
        ST_TX_WAIT: begin
          if (rel_i) begin
            state_d   = ST_TX;
            cnt_d     = '0;
            sda_low_d = ~shift_q[DW-1];
          end else if (load_i) begin
            shift_d = load_data_i;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CW'(DW - 1)) begin
              sda_low_d = 1'b0;
              cnt_d     = '0;
              state_d   = ST_TX_ACK;
            end else begin
              shift_d   = {shift_q[DW-2:0], 1'b0};
              sda_low_d = ~shift_q[DW-2];
              cnt_d     = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            evt_o.irq_set = 1'b1;
            if (nack_q) begin
              state_d        = ST_IDLE;
              evt_o.st_reset = 1'b1;
            end else begin
              state_d       = ST_TX_WAIT;
              evt_o.rel_clr = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      shift_q   <= '0;
      sda_low_q <= 1'b0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      shift_q   <= shift_d;
      sda_low_q <= sda_low_d;
      rw_q      <= rw_d;
      nack_q    <= nack_d;
    end
  end

  assign sda_low_o = sda_low_q;
  assign scl_low_o = (state_q == ST_TX_WAIT);
  assign rx_data_o = shift_q;

  // R12
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_q) |-> !$past(scl_s));

  // R8
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX_WAIT && !rel_i && !stop_det && !start_det) |=> scl_low_o);

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !sda_low_q);

  // R10
  master_ack_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX_ACK) |-> !sda_low_q);

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!scl_low_o && !sda_low_q));

endmodule

// File: rtl/i2c_ss_regs.sv
module i2c_ss_regs
  import i2c_ss_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_wr_i,
  input  logic [DW-1:0] buf_wdata_i,
  input  logic          buf_rd_i,
  input  logic          rel_set_i,
  input  logic          irq_clr_i,
  input  logic          ovf_clr_i,
  input  ss_evt_t       evt_i,
  input  logic [DW-1:0] rx_data_i,
  output logic [DW-1:0] buf_o,
  output logic          bf_o,
  output logic          ovf_o,
  output logic          irq_o,
  output logic          rel_o
);

  logic [DW-1:0] buf_q, buf_d;
  logic          bf_q, bf_d;
  logic          ovf_q, ovf_d;
  logic          irq_q, irq_d;
  logic          rel_q, rel_d;
  logic          armed_q, armed_d;

  always_comb begin
    buf_d   = buf_q;
    bf_d    = bf_q;
    ovf_d   = ovf_q;
    irq_d   = irq_q;
    rel_d   = rel_q;
    armed_d = armed_q;

    if (evt_i.rx_load)    buf_d = rx_data_i;
    else if (buf_wr_i)    buf_d = buf_wdata_i;

    if (evt_i.rx_load)                    bf_d = 1'b1;
    else if (evt_i.st_reset || buf_rd_i)  bf_d = 1'b0;

    if (evt_i.ovf_set)    ovf_d = 1'b1;
    else if (ovf_clr_i)   ovf_d = 1'b0;

    if (evt_i.irq_set)    irq_d = 1'b1;
    else if (irq_clr_i)   irq_d = 1'b0;

    if (evt_i.rel_clr || evt_i.st_reset)  armed_d = 1'b0;
    else if (buf_wr_i)                    armed_d = 1'b1;

    if (evt_i.rel_clr || evt_i.st_reset)  rel_d = 1'b0;
    else if (rel_set_i && armed_q)        rel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      bf_q    <= 1'b0;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
      rel_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      bf_q    <= bf_d;
      ovf_q   <= ovf_d;
      irq_q   <= irq_d;
      rel_q   <= rel_d;
      armed_q <= armed_d;
    end
  end

  assign buf_o = buf_q;
  assign bf_o  = bf_q;
  assign ovf_o = ovf_q;
  assign irq_o = irq_q;
  assign rel_o = rel_q;

  // R5
  ovf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(bf_q));

  // R4
  load_needs_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bf_q) |-> !$past(ovf_q));

  // R9
  release_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> $past(armed_q));

endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
  import i2c_ss_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              buf_rd_i,
  output logic [DATA_W-1:0] buf_rdata_o,
  input  logic              rel_set_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              rel_o
);

  logic              rst_sync_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              bf, ovf, rel;
  ss_evt_t           evt;
  logic [DATA_W-1:0] rx_data;

  i2c_ss_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .rst_sync_n (rst_sync_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det)
  );

  i2c_ss_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .own_addr_i  (own_addr_i),
    .scl_s       (scl_s),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .bf_i        (bf),
    .ovf_i       (ovf),
    .rel_i       (rel),
    .load_i      (buf_wr_i),
    .load_data_i (buf_wdata_i),
    .sda_low_o   (sda_low_o),
    .scl_low_o   (scl_low_o),
    .evt_o       (evt),
    .rx_data_o   (rx_data)
  );

  i2c_ss_regs #(.DW(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .buf_wr_i    (buf_wr_i),
    .buf_wdata_i (buf_wdata_i),
    .buf_rd_i    (buf_rd_i),
    .rel_set_i   (rel_set_i),
    .irq_clr_i   (irq_clr_i),
    .ovf_clr_i   (ovf_clr_i),
    .evt_i       (evt),
    .rx_data_i   (rx_data),
    .buf_o       (buf_rdata_o),
    .bf_o        (bf),
    .ovf_o       (ovf),
    .irq_o       (irq_o),
    .rel_o       (rel)
  );

  assign buf_full_o = bf;
  assign ovf_o      = ovf;
  assign rel_o      = rel;

endmodule

// File: tb/i2c_stretch_slave_test.sv
module i2c_stretch_slave_test;

  localparam int HP = 16;
  localparam logic [6:0] MY_ADDR    = 7'h2A;
  localparam logic [6:0] OTHER_ADDR = 7'h15;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl, m_sda;
  logic       scl_line, sda_line;
  logic       scl_low_o, sda_low_o;
  logic       buf_wr_i, buf_rd_i, rel_set_i, irq_clr_i, ovf_clr_i;
  logic [7:0] buf_wdata_i, buf_rdata_o;
  logic       buf_full_o, ovf_o, irq_o, rel_o;

  int n_chk  = 0;
  int n_fail = 0;
  int r12_bad = 0;
  logic prev_sda_low, prev_scl_line;

  always #4 clk = ~clk;

  assign scl_line = m_scl & ~scl_low_o;
  assign sda_line = m_sda & ~sda_low_o;

  i2c_stretch_slave uut (
    .clk(clk), .rst_n(rst_n), .own_addr_i(MY_ADDR),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .buf_wr_i(buf_wr_i), .buf_wdata_i(buf_wdata_i), .buf_rd_i(buf_rd_i),
    .buf_rdata_o(buf_rdata_o), .rel_set_i(rel_set_i), .irq_clr_i(irq_clr_i),
    .ovf_clr_i(ovf_clr_i), .buf_full_o(buf_full_o), .ovf_o(ovf_o),
    .irq_o(irq_o), .rel_o(rel_o)
  );

  // R12 monitor: SDA pull-down may only move while SCL was low
  always @(negedge clk) begin
    if (rst_n === 1'b1 && sda_low_o !== prev_sda_low && prev_scl_line === 1'b1)
      r12_bad++;
    prev_sda_low  = sda_low_o;
    prev_scl_line = scl_line;
  end

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_strobe(input int which, input logic [7:0] d);
    @(negedge clk);
    buf_wdata_i = d;
    case (which)
      0: buf_wr_i  = 1'b1;
      1: buf_rd_i  = 1'b1;
      2: rel_set_i = 1'b1;
      3: irq_clr_i = 1'b1;
      default: ovf_clr_i = 1'b1;
    endcase
    @(negedge clk);
    buf_wr_i = 0; buf_rd_i = 0; rel_set_i = 0; irq_clr_i = 0; ovf_clr_i = 0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; idle(HP);
    m_sda = 1'b0; idle(HP);
    m_scl = 1'b0; idle(HP/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; idle(HP/2);
    m_scl = 1'b1;
    while (scl_line !== 1'b1) @(negedge clk);
    idle(HP);
    m_sda = 1'b1; idle(HP);
  endtask

  task automatic pulse(output logic s);
    m_scl = 1'b1;
    while (scl_line !== 1'b1) @(negedge clk);
    idle(HP/2);
    s = sda_line;
    idle(HP/2);
    m_scl = 1'b0;
    idle(HP/2);
  endtask

  task automatic send_bit(input logic b);
    logic s;
    m_sda = b; idle(HP/2);
    pulse(s);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    m_sda = 1'b1; idle(HP/2);
    pulse(s);
    acked = (s == 1'b0);
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; idle(HP/2);
      pulse(s);
      d[i] = s;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; idle(HP/2);
    pulse(s);
    m_sda = 1'b1;
  endtask

  task automatic t_reset();
    check_eq("R1", "buf_full", buf_full_o, 0);
    check_eq("R1", "ovf", ovf_o, 0);
    check_eq("R1", "irq", irq_o, 0);
    check_eq("R1", "rel", rel_o, 0);
    check_eq("R1", "drives", {scl_low_o, sda_low_o}, 0);
  endtask

  task automatic t_write_path();
    logic a;
    bus_start();
    write_byte({MY_ADDR, 1'b0}, a);
    check_eq("R2", "addr ack", a, 1);
    check_eq("R2", "irq after addr", irq_o, 1);
    cpu_strobe(3, 8'h00);
    check_eq("R7", "irq cleared", irq_o, 0);
    write_byte(8'hA5, a);
    check_eq("R4", "data ack", a, 1);
    check_eq("R4", "buffer", buf_rdata_o, 8'hA5);
    check_eq("R4", "buf_full", buf_full_o, 1);
    check_eq("R4", "irq", irq_o, 1);
    cpu_strobe(3, 8'h00);
    // R5: buffer still full
    write_byte(8'h3C, a);
    check_eq("R5", "nack when full", a, 0);
    check_eq("R5", "ovf set", ovf_o, 1);
    check_eq("R5", "buffer kept", buf_rdata_o, 8'hA5);
    check_eq("R5", "irq still set", irq_o, 1);
    cpu_strobe(3, 8'h00);
    cpu_strobe(1, 8'h00);
    check_eq("R7", "read clears buf_full", buf_full_o, 0);
    // R6: overrun persists with empty buffer
    write_byte(8'h5A, a);
    check_eq("R6", "nack while ovf", a, 0);
    check_eq("R6", "buffer kept", buf_rdata_o, 8'hA5);
    check_eq("R6", "buf_full stays 0", buf_full_o, 0);
    check_eq("R6", "irq set", irq_o, 1);
    cpu_strobe(4, 8'h00);
    check_eq("R7", "ovf cleared", ovf_o, 0);
    write_byte(8'h0F, a);
    check_eq("R6", "ack after clear", a, 1);
    check_eq("R6", "buffer new", buf_rdata_o, 8'h0F);
    cpu_strobe(1, 8'h00);
    cpu_strobe(3, 8'h00);
    bus_stop();
  endtask

  task automatic t_no_match();
    logic a;
    bus_start();
    write_byte({OTHER_ADDR, 1'b0}, a);
    check_eq("R3", "no addr ack", a, 0);
    check_eq("R3", "no irq", irq_o, 0);
    write_byte(8'hFF, a);
    check_eq("R3", "data ignored", a, 0);
    check_eq("R3", "buf_full", buf_full_o, 0);
    check_eq("R3", "irq", irq_o, 0);
    bus_stop();
  endtask

  task automatic t_read_path();
    logic a;
    logic [7:0] d;
    bus_start();
    write_byte({MY_ADDR, 1'b1}, a);
    check_eq("R2", "read addr ack", a, 1);
    idle(8);
    check_eq("R8", "scl held", scl_low_o, 1);
    check_eq("R8", "irq", irq_o, 1);
    check_eq("R8", "rel cleared", rel_o, 0);
    cpu_strobe(3, 8'h00);
    cpu_strobe(2, 8'h00);
    idle(40);
    check_eq("R9", "release without write ignored", scl_low_o, 1);
    check_eq("R9", "rel stays 0", rel_o, 0);
    cpu_strobe(0, 8'hC3);
    cpu_strobe(2, 8'h00);
    check_eq("R9", "rel set", rel_o, 1);
    read_byte(1'b1, d);
    check_eq("R9", "first byte", d, 8'hC3);
    idle(8);
    check_eq("R10", "hold again after ack", scl_low_o, 1);
    check_eq("R10", "rel cleared", rel_o, 0);
    check_eq("R10", "irq", irq_o, 1);
    cpu_strobe(3, 8'h00);
    cpu_strobe(0, 8'h96);
    cpu_strobe(2, 8'h00);
    read_byte(1'b0, d);
    check_eq("R9", "second byte", d, 8'h96);
    idle(8);
    check_eq("R10", "bus free after nack", {scl_low_o, sda_low_o}, 0);
    check_eq("R10", "rel after nack", rel_o, 0);
    check_eq("R10", "buf_full after nack", buf_full_o, 0);
    cpu_strobe(3, 8'h00);
    write_byte({MY_ADDR, 1'b0}, a);
    check_eq("R10", "ignored until start", a, 0);
    bus_stop();
  endtask

  task automatic t_stop_abort();
    logic a;
    bus_start();
    write_byte({MY_ADDR, 1'b0}, a);
    check_eq("R2", "addr ack", a, 1);
    cpu_strobe(3, 8'h00);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    check_eq("R11", "bus free after stop", {scl_low_o, sda_low_o}, 0);
    bus_start();
    bus_stop();
    m_scl = 1'b0; idle(HP/2);
    write_byte({MY_ADDR, 1'b0}, a);
    check_eq("R11", "idle ignores byte", a, 0);
    check_eq("R11", "no irq", irq_o, 0);
    m_scl = 1'b1; m_sda = 1'b1; idle(HP);
  endtask

  initial begin
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    buf_wr_i = 0; buf_rd_i = 0; rel_set_i = 0; irq_clr_i = 0; ovf_clr_i = 0;
    buf_wdata_i = '0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_write_path();
    t_no_match();
    t_read_path();
    t_stop_abort();
    check_eq("R12", "sda changes while scl high", r12_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule